// File: doc/BRIEF.md
# Scan-Testable Two-Stage Adder Pipeline

This block adds two unsigned operands through a two-register pipeline. The first stage registers both operands. An adder combines the registered operands. The second stage registers the sum, which is one bit wider than an operand and so keeps the carry. In normal operation a sum appears two clock edges after its operands are presented.

Every flip-flop in the block is a mux-D test cell. When the test enable is high, all register bits form one serial shift path that starts at a dedicated serial input and ends at a dedicated serial output. A tester fills every register through that path, drops the enable for a single capture edge, and then raises it again to shift the captured state out. The internal adder result then becomes visible one bit at a time. The order of the bits along the path is fixed so that a tester can map serial positions to register bits.

Top module: `scan_add_pipe`

## Requirements
- R1: With `scan_en` low, a rising edge loads `op_a` into operand register A and `op_b` into operand register B.
- R2: With `scan_en` low for two consecutive edges, `sum_o` equals the zero-extended sum `op_a + op_b` presented before the first of those edges, carry in bit WIDTH (e.g. 0xFF + 0x01 = 0x100).
- R3: With `scan_en` high, every register bit loads its chain predecessor on each rising edge, so the whole chain advances one position per clock.
- R4: The chain position index counts from `scan_in`. Positions 0..WIDTH-1 are A[0]..A[WIDTH-1], positions WIDTH..2*WIDTH-1 are B[0]..B[WIDTH-1], and positions 2*WIDTH..3*WIDTH are sum bits 0..WIDTH. `scan_out` is sum bit WIDTH, and `sum_o` shows the sum register in parallel.
- R5: The chain is 3*WIDTH+1 bits long. A single 1 shifted in at `scan_in` into an all-zero chain appears at `scan_out` after exactly 3*WIDTH+1 shift edges and not earlier.
- R6: Reset is synchronous and active high. It clears every register bit on a rising edge whatever the level of `scan_en`, leaving `sum_o` = 0 and `scan_out` = 0.
- R7: While `scan_en` is high, `op_a` and `op_b` have no effect on any register. The register contents come only from the chain.
- R8: One edge with `scan_en` low after a scan load captures the sum of the scanned-in A and B values into the sum register.
- R9: `scan_en` is active high: level 1 selects the chain input of every cell and level 0 selects the functional input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all register bits |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First functional operand |
| op_b | input | WIDTH | Second functional operand |
| scan_en | input | 1 | Test enable: 1 = shift along the chain, 0 = functional load |
| scan_in | input | 1 | Serial input to chain position 0 |
| sum_o | output | WIDTH+1 | Registered sum with carry |
| scan_out | output | 1 | Serial output, last chain position |

## Verification
The properties assume that `scan_en`, `scan_in` and both operands hold known values and stay stable around each rising edge. They also assume that reset is held high from time zero until after the first edge, because the capture and shift relations compare against the previous cycle only. The bench meets these assumptions. It changes every input on the falling edge, so each value settles half a period before the next rising edge. It raises reset before the first clock and keeps it up for several cycles. During shift phases it also keeps the operands at non-zero values, so that any leak of functional data into the chain would change what is captured.

// File: rtl/scan_pipe_pkg.sv
package scan_pipe_pkg;

    // Selection made by every mux-D cell.
    typedef enum logic {
        MODE_FUNC  = 1'b0,
        MODE_SHIFT = 1'b1
    } cell_mode_e;

    // Default operand width used by the top module.
    localparam int DEFAULT_WIDTH = 8;

    // Operand stage A, operand stage B and the carry-extended sum stage.
    function automatic int chain_len(input int width);
        return 3 * width + 1;
    endfunction

    // Active-high enable maps directly to the cell mode with no inversion.
    function automatic cell_mode_e mode_from_enable(input logic enable);
        return enable ? MODE_SHIFT : MODE_FUNC;
    endfunction

endpackage

// File: rtl/scan_cell_bank.sv
module scan_cell_bank
    import scan_pipe_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_mode_e       mode,
    input  logic             chain_in,
    input  logic [NBITS-1:0] d_func,
    output logic [NBITS-1:0] q,
    output logic             chain_out
);

    logic [NBITS-1:0] shift_src;

    // Bit 0 takes the bank's serial input, bit i takes bit i-1.
    generate
        if (NBITS == 1) begin : g_single
            assign shift_src = chain_in;
        end else begin : g_multi
            assign shift_src = {q[NBITS-2:0], chain_in};
        end
    endgenerate

    generate
        for (genvar i = 0; i < NBITS; i++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[i] <= 1'b0;
                end else if (mode == MODE_SHIFT) begin
                    q[i] <= shift_src[i];
                end else begin
                    q[i] <= d_func[i];
                end
            end
        end
    endgenerate

    assign chain_out = q[NBITS-1];

endmodule

// File: rtl/pipe_adder.sv
module pipe_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH:0]   total
);

    logic [WIDTH:0] carry;

    // Ripple structure written out per bit.
    assign carry[0] = 1'b0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign total[i]   = lhs[i] ^ rhs[i] ^ carry[i];
            assign carry[i+1] = (lhs[i] & rhs[i]) | (carry[i] & (lhs[i] ^ rhs[i]));
        end
    endgenerate

    assign total[WIDTH] = carry[WIDTH];

endmodule

// File: rtl/scan_add_pipe.sv
module scan_add_pipe
    import scan_pipe_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             scan_en,
    input  logic             scan_in,
    output logic [WIDTH:0]   sum_o,
    output logic             scan_out
);

    cell_mode_e       mode;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH:0]   sum_d;
    logic [WIDTH:0]   sum_q;
    logic             a_tail;
    logic             b_tail;

    assign mode = mode_from_enable(scan_en);

    // Chain order: scan_in -> A bank -> B bank -> sum bank -> scan_out.
    scan_cell_bank #(.NBITS(WIDTH)) u_bank_a (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .chain_in  (scan_in),
        .d_func    (op_a),
        .q         (a_q),
        .chain_out (a_tail)
    );

    scan_cell_bank #(.NBITS(WIDTH)) u_bank_b (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .chain_in  (a_tail),
        .d_func    (op_b),
        .q         (b_q),
        .chain_out (b_tail)
    );

    pipe_adder #(.WIDTH(WIDTH)) u_add (
        .lhs   (a_q),
        .rhs   (b_q),
        .total (sum_d)
    );

    scan_cell_bank #(.NBITS(WIDTH + 1)) u_bank_sum (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .chain_in  (b_tail),
        .d_func    (sum_d),
        .q         (sum_q),
        .chain_out (scan_out)
    );

    assign sum_o = sum_q;

endmodule

// File: rtl/scan_pipe_chk.sv
module scan_pipe_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             scan_en,
    input logic             scan_in,
    input logic [WIDTH:0]   sum_o,
    input logic             scan_out,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (sum_o == '0 && scan_out == 1'b0 && a_q == '0 && b_q == '0)); // R6

    AST_FUNC_LOADS_A: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (a_q == $past(op_a) && b_q == $past(op_b))); // R1

    AST_FUNC_SUM: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (sum_o == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}))); // R2

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (a_q[0] == $past(scan_in))); // R3

    AST_SHIFT_A_TO_B: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (b_q[0] == $past(a_q[WIDTH-1]))); // R4

    AST_SHIFT_B_TO_SUM: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (sum_o[0] == $past(b_q[WIDTH-1]))); // R4

    AST_SHIFT_TAIL: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (scan_out == $past(sum_o[WIDTH-1]))); // R3

    AST_SHIFT_IGNORES_OPS: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (a_q[WIDTH-1:1] == $past(a_q[WIDTH-2:0]))); // R7

endmodule

bind scan_add_pipe scan_pipe_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .sum_o    (sum_o),
    .scan_out (scan_out),
    .a_q      (a_q),
    .b_q      (b_q)
);

// File: tb/test_scan_add_pipe.sv
`timescale 1ns/1ps
module test_scan_add_pipe;
    import scan_pipe_pkg::*;

    localparam int W = 8;
    localparam int L = 3 * W + 1;
    localparam int NVEC = 6;

    // {op_a, op_b, expected sum}
    localparam logic [3*W:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 9'h000},
        {8'hFF, 8'h01, 9'h100},
        {8'hFF, 8'hFF, 9'h1FE},
        {8'h12, 8'h34, 9'h046},
        {8'h80, 8'h80, 9'h100},
        {8'hA5, 8'h5A, 9'h0FF}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [W:0]   sum_o;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scan_add_pipe #(.WIDTH(W)) i_scan_add_pipe (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .sum_o    (sum_o),
        .scan_out (scan_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [L-1:0] pack(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W:0] s);
        return {s, b, a};
    endfunction

    // Shift a full chain in while capturing the previous contents from scan_out.
    task automatic scan_xfer(input logic [L-1:0] load, output logic [L-1:0] got);
        scan_en = 1'b1;
        for (int k = L - 1; k >= 0; k--) begin
            got[k] = scan_out;
            scan_in = load[k];
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [L-1:0] got;
        logic [L-1:0] pat;

        // Reset state
        repeat (3) @(negedge clk);
        chk("R6 reset sum", 32'(sum_o), 32'h0);
        chk("R6 reset scan_out", 32'(scan_out), 32'h0);
        rst = 1'b0;

        // Functional vectors (R2, R9: enable low selects functional path)
        scan_en = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            op_a = VEC[v][3*W:2*W+1];
            op_b = VEC[v][2*W:W+1];
            repeat (2) @(negedge clk);
            chk("R2 R9 functional sum", 32'(sum_o), 32'(VEC[v][W:0]));
        end

        // Scan load with operands held busy (R4, R7)
        op_a = 8'hC3;
        op_b = 8'h3C;
        pat = pack(8'h5A, 8'h96, 9'h1A7);
        scan_xfer(pat, got);
        chk("R4 R7 sum stage after load", 32'(sum_o), 32'h1A7);
        chk("R4 scan_out is sum top bit", 32'(scan_out), 32'h1);

        // One extra shift (R3)
        scan_in = 1'b1;
        @(negedge clk);
        pat = {pat[L-2:0], 1'b1};
        chk("R3 sum after one shift", 32'(sum_o), 32'(pat[L-1:2*W]));

        // Unload and compare whole chain (R3, R4, R7)
        scan_xfer('0, got);
        chk("R4 R7 unloaded chain low", 32'(got[31:0]), 32'(pat[31:0]));
        chk("R4 unloaded chain high", 32'(got[L-1:W]), 32'(pat[L-1:W]));

        // Load, capture, unload (R8, R1)
        scan_xfer(pack(8'hFF, 8'h01, 9'h000), got);
        scan_en = 1'b0;
        op_a = 8'h03;
        op_b = 8'h04;
        @(negedge clk);
        chk("R8 captured scanned sum", 32'(sum_o), 32'h100);
        scan_xfer('0, got);
        chk("R1 R8 unloaded after capture", 32'(got), 32'(pack(8'h03, 8'h04, 9'h100)));

        // Reset during shift mode (R6)
        scan_xfer({L{1'b1}}, got);
        scan_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R6 reset with scan_en high sum", 32'(sum_o), 32'h0);
        chk("R6 reset with scan_en high scan_out", 32'(scan_out), 32'h0);
        rst = 1'b0;
        scan_xfer('0, got);
        chk("R6 chain cleared", 32'(got), 32'h0);

        // Chain length (R5)
        scan_en = 1'b1;
        scan_in = 1'b1;
        @(negedge clk);
        scan_in = 1'b0;
        for (int n = 1; n <= L; n++) begin
            if (n >= L - 1)
                chk("R5 token arrival", 32'(scan_out), (n == L) ? 32'h1 : 32'h0);
            if (n < L) @(negedge clk);
        end

        finish_run();
    end

endmodule